// File: doc/BRIEF.md
# Real-time clock time registers with host snapshot

This block keeps calendar time in BCD and shows it to a host through eight byte registers. Running counters hold seconds, minutes, hours, weekday, date, month and year. A divider turns oscillator-rate pulses into a one-second tick. A separate user copy of the seven time bytes is what the host reads. That copy is refreshed from the running counters after each tick. It is frozen while the host is in the middle of reading time bytes, so a multi-byte read sees one consistent instant.

The host port is a byte pointer with auto-increment:
- A load strobe sets the pointer.
- Each read or write access moves the pointer up by one, wrapping from 7 back to 0.
- A stop strobe marks the end of a transaction.

Writing a time address loads the running counter directly and clears the divider, so the next second starts counting from that write. Address 7 is a plain binary control byte that is read and written directly.

The view of the time bytes is run by a three-state machine:
- S_RUN: the copy follows each tick.
- S_HOLD: the copy is frozen.
- S_SYNC: a one-cycle state that reloads the copy from the counters.

Its transitions are:
- RUN→HOLD on a read of a time address that leaves the pointer inside 0–6.
- RUN→SYNC on a write to a time address.
- HOLD→SYNC on the stop strobe, or when the pointer reaches 7.
- SYNC→HOLD on a freezing read.
- SYNC→RUN otherwise.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the registers read 80h (stop bit set, seconds 00), 00h, 00h, 01h, 01h, 01h, 00h at addresses 0 to 6, and 00h at address 7.
- R2: Each tick advances seconds 00–59 (bits 6:0 of address 0). The carry chain then runs through minutes 00–59 (address 1), hours 00–23 (bits 5:0 of address 2) and weekday 1–7 (address 3), all in BCD.
- R3: Date (address 4) wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days, and the other months except February have 31. February has 29 days when the year value is a multiple of 4, and 28 days otherwise.
- R4: Month (address 5) wraps from 12 to 01 at the end of December, and year (address 6) then wraps from 99 to 00.
- R5: Bit 7 of address 2 is the century enable and bit 6 is the century flag. The flag inverts when the year wraps from 99 to 00 with enable at 1, and it keeps its value when enable is 0.
- R6: While bit 7 of address 0 is 1, neither the divider nor any time counter advances.
- R7: A write to any address 0–6 clears the divider. The next tick then comes exactly DIV_MAX oscillator pulses after that write. A write to address 7 leaves the divider alone.
- R8: A read access at an address 0–6 that leaves the pointer below 7 freezes the user copy. Ticks during the freeze still advance the running counters.
- R9: The freeze ends on the stop strobe or when the pointer becomes 7. The copy then shows the latest counter values.
- R10: Each read or write access without a pointer load increments the pointer, wrapping from 7 to 0. Address 7 holds a binary byte that is read back as written, independent of the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One pulse per oscillator period |
| ptr_load | input | 1 | Load the pointer from ptr_val (no access that cycle) |
| ptr_val | input | 3 | New pointer value |
| wr_en | input | 1 | Write wr_data at the pointer, then increment |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read access at the pointer, then increment |
| rd_data | output | 8 | Byte at the current pointer (user copy or control byte) |
| stop_strobe | input | 1 | End of host transaction |

## Verification
The bench builds the block with DIV_MAX set to 4. With that setting, one second costs four oscillator pulses. This makes calendar rollovers, divider clearing by a time write, and ticks landing inside a frozen read short and exactly countable. The bench controls every oscillator pulse, so it knows the exact count at which each second should change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_HOLD = 2'd1,
        S_SYNC = 2'd2
    } view_state_t;

    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned NUM_TIME = 7;

    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DAY  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd7;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] yr_bin;
        yr_bin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
        unique case (mon)
            8'h02:                      return (yr_bin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int unsigned DIV_MAX = 32768,
    localparam int unsigned CW = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc,
    input  logic clr,
    input  logic halt,
    output logic tick
);
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(DIV_MAX - 1));
    assign tick = osc && !halt && !clr && last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (osc && !halt) begin
            cnt <= last ? '0 : cnt + CW'(1);
        end
    end

    // R6: a halted divider keeps its count
    a_r6_halt_holds_div: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !clr |=> $stable(cnt));

endmodule

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter #(
    parameter logic [7:0] MIN_VAL = 8'h00,
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic [7:0] max_val,
    output logic [7:0] value,
    output logic       wrap
);
    import rtc_pkg::*;

    assign wrap = en && (value == max_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RST_VAL;
        end else if (ld) begin
            value <= ld_val;
        end else if (en) begin
            value <= (value == max_val) ? MIN_VAL : bcd_inc(value);
        end
    end

    // R2: a counter at its top value returns to its bottom value on the next step
    a_r2_wrap_to_min: assert property (@(posedge clk) disable iff (!rst_n)
        en && !ld && (value == max_val) |=> value == MIN_VAL);

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
    parameter int unsigned DIV_MAX = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       ptr_load,
    input  logic [2:0] ptr_val,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       stop_strobe
);
    import rtc_pkg::*;

    localparam logic [NUM_TIME-1:0][7:0] COPY_RST =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80};

    view_state_t state, state_nxt;

    logic [ADDR_W-1:0] ptr, ptr_nxt;
    logic              wr_hit, rd_hit, wr_time;
    logic              freeze_req, release_req, copy_now;
    logic              tick, tick_q;
    logic              st_q, ceb_q, cb_q;
    logic [7:0]        ctrl_q;
    logic [7:0]        sec_v, min_v, hr_v, day_v, date_v, mon_v, yr_v;
    logic              sec_w, min_w, hr_w, day_w, date_w, mon_w, yr_w;
    logic [7:0]        mdays;
    logic [NUM_TIME-1:0][7:0] live, shadow;
    logic [7:0][7:0]   view;

    // host access decode
    assign wr_hit  = wr_en && !ptr_load;
    assign rd_hit  = rd_en && !wr_en && !ptr_load;
    assign wr_time = wr_hit && (ptr != A_CTRL);

    always_comb begin
        if (ptr_load)             ptr_nxt = ptr_val;
        else if (wr_hit || rd_hit) ptr_nxt = ptr + 3'd1;
        else                      ptr_nxt = ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= A_SEC;
        else        ptr <= ptr_nxt;
    end

    // R10: the pointer wraps from the last address to the first
    a_r10_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == A_CTRL) && (rd_hit || wr_hit) |=> ptr == A_SEC);

    // divider and one-second tick
    rtc_divider #(.DIV_MAX(DIV_MAX)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .osc  (osc_tick),
        .clr  (wr_time),
        .halt (st_q),
        .tick (tick)
    );

    // time counters
    assign mdays = last_day(mon_v, yr_v);

    rtc_bcd_counter #(.MIN_VAL(8'h00), .RST_VAL(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .en(tick), .ld(wr_hit && ptr == A_SEC),
        .ld_val({1'b0, wr_data[6:0]}), .max_val(8'h59), .value(sec_v), .wrap(sec_w));
    rtc_bcd_counter #(.MIN_VAL(8'h00), .RST_VAL(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .en(sec_w), .ld(wr_hit && ptr == A_MIN),
        .ld_val({1'b0, wr_data[6:0]}), .max_val(8'h59), .value(min_v), .wrap(min_w));
    rtc_bcd_counter #(.MIN_VAL(8'h00), .RST_VAL(8'h00)) u_hour (
        .clk(clk), .rst_n(rst_n), .en(min_w), .ld(wr_hit && ptr == A_HOUR),
        .ld_val({2'b00, wr_data[5:0]}), .max_val(8'h23), .value(hr_v), .wrap(hr_w));
    rtc_bcd_counter #(.MIN_VAL(8'h01), .RST_VAL(8'h01)) u_day (
        .clk(clk), .rst_n(rst_n), .en(hr_w), .ld(wr_hit && ptr == A_DAY),
        .ld_val({5'b00000, wr_data[2:0]}), .max_val(8'h07), .value(day_v), .wrap(day_w));
    rtc_bcd_counter #(.MIN_VAL(8'h01), .RST_VAL(8'h01)) u_date (
        .clk(clk), .rst_n(rst_n), .en(hr_w), .ld(wr_hit && ptr == A_DATE),
        .ld_val({2'b00, wr_data[5:0]}), .max_val(mdays), .value(date_v), .wrap(date_w));
    rtc_bcd_counter #(.MIN_VAL(8'h01), .RST_VAL(8'h01)) u_mon (
        .clk(clk), .rst_n(rst_n), .en(date_w), .ld(wr_hit && ptr == A_MON),
        .ld_val({3'b000, wr_data[4:0]}), .max_val(8'h12), .value(mon_v), .wrap(mon_w));
    rtc_bcd_counter #(.MIN_VAL(8'h00), .RST_VAL(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .en(mon_w), .ld(wr_hit && ptr == A_YEAR),
        .ld_val(wr_data), .max_val(8'h99), .value(yr_v), .wrap(yr_w));

    // stop, century and control bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= 1'b1;
            ceb_q  <= 1'b0;
            cb_q   <= 1'b0;
            ctrl_q <= 8'h00;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick;
            if (wr_hit && ptr == A_SEC) st_q <= wr_data[7];
            if (wr_hit && ptr == A_HOUR) begin
                ceb_q <= wr_data[7];
                cb_q  <= wr_data[6];
            end else if (yr_w && ceb_q) begin
                cb_q <= ~cb_q;
            end
            if (wr_hit && ptr == A_CTRL) ctrl_q <= wr_data;
        end
    end

    // R5: century flag inverts on a year wrap while enabled
    a_r5_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
        yr_w && ceb_q && !(wr_hit && ptr == A_HOUR) |=> cb_q != $past(cb_q));

    // R6: with the stop bit set and no write, time does not move
    a_r6_stop_freezes_time: assert property (@(posedge clk) disable iff (!rst_n)
        st_q && !wr_hit |=> $stable({sec_v, min_v, hr_v, day_v, date_v, mon_v, yr_v}));

    always_comb begin
        live[A_SEC]  = {st_q, sec_v[6:0]};
        live[A_MIN]  = min_v;
        live[A_HOUR] = {ceb_q, cb_q, hr_v[5:0]};
        live[A_DAY]  = day_v;
        live[A_DATE] = date_v;
        live[A_MON]  = mon_v;
        live[A_YEAR] = yr_v;
    end

    // snapshot state machine
    assign freeze_req  = rd_hit && (ptr != A_CTRL) && (ptr_nxt != A_CTRL) && !stop_strobe;
    assign release_req = stop_strobe || (ptr_nxt == A_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_RUN: begin
                if (freeze_req)   state_nxt = S_HOLD;
                else if (wr_time) state_nxt = S_SYNC;
            end
            S_HOLD: begin
                if (release_req)  state_nxt = S_SYNC;
            end
            S_SYNC: begin
                state_nxt = freeze_req ? S_HOLD : S_RUN;
            end
            default: state_nxt = S_RUN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        copy_now = (state == S_SYNC) || ((state == S_RUN) && tick_q);
        view[6:0] = shadow;
        view[7]   = ctrl_q;
        rd_data   = view[ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        shadow <= COPY_RST;
        else if (copy_now) shadow <= live;
    end

    // R8: the user copy does not change while frozen
    a_r8_hold_keeps_copy: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_HOLD |=> $stable(shadow));

    // R9: the stop strobe ends a freeze
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) && stop_strobe |=> state == S_SYNC);

endmodule

// File: tb/rtc_regfile_test.sv
`timescale 1ns/1ps
module rtc_regfile_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       ptr_load = 1'b0;
    logic [2:0] ptr_val = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       stop_strobe = 1'b0;

    int total = 0;
    int bad = 0;
    logic [7:0] got [0:6];
    logic [7:0] tmp;

    always #2.5 clk = ~clk;

    rtc_regfile #(.DIV_MAX(4)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ptr_load(ptr_load),
        .ptr_val(ptr_val), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .stop_strobe(stop_strobe));

    // {date, month, year, expected date, expected month, expected year}
    localparam logic [47:0] VEC [0:8] = '{
        48'h31_01_24_01_02_24,
        48'h28_02_23_01_03_23,
        48'h28_02_24_29_02_24,
        48'h29_02_24_01_03_24,
        48'h30_04_25_01_05_25,
        48'h31_12_99_01_01_00,
        48'h15_06_10_16_06_10,
        48'h30_09_07_01_10_07,
        48'h28_02_00_29_02_00
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [2:0] a);
        ptr_load = 1'b1; ptr_val = a;
        @(posedge clk); @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        d = rd_data;
        rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic end_txn();
        stop_strobe = 1'b1;
        @(posedge clk); @(negedge clk);
        stop_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic osc_run(input int n);
        osc_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic read_regs();
        set_ptr(3'd0);
        for (int i = 0; i < 7; i++) rd(got[i]);
        end_txn();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents
        read_regs();
        chk("R1 sec", got[0], 8'h80);
        chk("R1 min", got[1], 8'h00);
        chk("R1 hour", got[2], 8'h00);
        chk("R1 day", got[3], 8'h01);
        chk("R1 date", got[4], 8'h01);
        chk("R1 month", got[5], 8'h01);
        chk("R1 year", got[6], 8'h00);
        set_ptr(3'd7);
        chk("R1 ctrl", rd_data, 8'h00);

        // R6 stop bit from reset holds time
        osc_run(12); idle(3);
        read_regs();
        chk("R6 halted sec", got[0], 8'h80);

        // calendar table: 23:59:59 weekday 7, one tick
        for (int i = 0; i < 9; i++) begin
            set_ptr(3'd0);
            wr(8'h59); wr(8'h59); wr(8'h23); wr(8'h07);
            wr(VEC[i][47:40]); wr(VEC[i][39:32]); wr(VEC[i][31:24]);
            end_txn();
            osc_run(4); idle(3);
            read_regs();
            chk("R2 sec wrap", got[0], 8'h00);
            chk("R2 min wrap", got[1], 8'h00);
            chk("R2 hour wrap", got[2], 8'h00);
            chk("R2 weekday wrap", got[3], 8'h01);
            chk("R3 date", got[4], VEC[i][23:16]);
            chk("R4 month", got[5], VEC[i][15:8]);
            chk("R4 year", got[6], VEC[i][7:0]);
        end

        // R5 century flag toggles with enable
        set_ptr(3'd0);
        wr(8'h59); wr(8'h59); wr(8'hA3); wr(8'h02); wr(8'h31); wr(8'h12); wr(8'h99);
        end_txn(); osc_run(4); idle(3); read_regs();
        chk("R5 century toggled", got[2], 8'hC0);
        chk("R4 year 99 wrap", got[6], 8'h00);
        // R5 flag holds with enable clear
        set_ptr(3'd0);
        wr(8'h59); wr(8'h59); wr(8'h63); wr(8'h02); wr(8'h31); wr(8'h12); wr(8'h99);
        end_txn(); osc_run(4); idle(3); read_regs();
        chk("R5 century held", got[2], 8'h40);

        // R6 stop bit written, then cleared
        set_ptr(3'd0); wr(8'h85); end_txn();
        osc_run(12); idle(3); read_regs();
        chk("R6 stopped sec", got[0], 8'h85);
        set_ptr(3'd0); wr(8'h05); end_txn();
        osc_run(4); idle(3); read_regs();
        chk("R6 running sec", got[0], 8'h06);

        // R7 time write clears the divider
        set_ptr(3'd0); wr(8'h10); end_txn();
        osc_run(3);
        set_ptr(3'd1); wr(8'h00); end_txn();
        osc_run(3); idle(3); read_regs();
        chk("R7 no tick yet", got[0], 8'h10);
        osc_run(1); idle(3); read_regs();
        chk("R7 tick after full count", got[0], 8'h11);
        // R7 control write keeps the divider count
        osc_run(3);
        set_ptr(3'd7); wr(8'h3C); end_txn();
        osc_run(1); idle(3); read_regs();
        chk("R7 ctrl write no clear", got[0], 8'h12);

        // R8 freeze during read, R9 release on stop
        set_ptr(3'd0); wr(8'h20); end_txn(); idle(3);
        set_ptr(3'd0); rd(tmp);
        chk("R8 first read", tmp, 8'h20);
        osc_run(8); idle(3);
        set_ptr(3'd0);
        chk("R8 copy frozen", rd_data, 8'h20);
        end_txn(); idle(2);
        chk("R9 stop shows latest", rd_data, 8'h22);

        // R9 release when pointer reaches 7
        set_ptr(3'd0); wr(8'h30); end_txn(); idle(3);
        set_ptr(3'd5); rd(tmp);
        osc_run(4); idle(3);
        rd(tmp);
        idle(2);
        set_ptr(3'd0);
        chk("R9 pointer release", rd_data, 8'h31);

        // R10 pointer wrap and control byte
        set_ptr(3'd7); wr(8'hA5); wr(8'h40); end_txn(); idle(3);
        set_ptr(3'd7);
        chk("R10 ctrl byte", rd_data, 8'hA5);
        rd(tmp);
        chk("R10 wrapped write", rd_data, 8'h40);
        end_txn();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule